// File: doc/BRIEF.md
# DRAM Strobe Sequencer

This block is a clocked state machine that produces the row strobe, the primary column strobe, a secondary column strobe and the write enable for one DRAM access. It also produces a 2-bit sub-state tag. Each state code is the strobe pattern itself. Bit 5 is the row strobe, bit 4 the primary column strobe, bit 3 the secondary column strobe, bit 2 the write enable and bits 1:0 the tag. The output pins carry the bitwise inverse of the state register, so every strobe is active-low.

An access starts from idle when a request is seen. After one row-only cycle the machine branches on the read/write select. A single access uses two column cycles. A quad-word access adds beats that alternate between the secondary and primary column strobes. A stall input holds the column cycles in place. On the read side, a correctable-error flag inserts one extra cycle after any burst beat, and a further cycle after the row is released. From that further cycle a new request can begin at once.

The four tag values are parameters. They must form a permutation of 0 to 3. The idle tag is the third of them.

Top module: `dram_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the machine in idle: all four strobe pins high and tag_n equal to the inverse of SUB_C.
- R2: The pins always equal the bitwise inverse of the 6-bit state {row, primary column, secondary column, write, tag[1:0]}, in that bit order from bit 5 down to bit 0.
- R3: From idle, a request moves the machine to the row-only state (tag SUB_A). From there it moves to the read column state (row+column, tag SUB_B) if rd is high, or to the write column state (row+column, tag SUB_D) if rd is low.
- R4: The first read column state and the first write column state each hold while stall is high.
- R5: In a write, the column+write state (tag SUB_A) moves to the write-only state (tag 0) when quad is low. The write-only state returns to idle.
- R6: In a write burst with quad high, the column+write state holds on stall and otherwise moves to a secondary-column+write beat (tag SUB_B). That beat moves to a column+write state (tag SUB_B) if stall is high, where it waits for stall to fall, and then to the beat with tag SUB_D. The same pattern repeats with tag SUB_D, then comes the beat with tag SUB_C, then write-only.
- R7: In a read, the second column state (tag SUB_A) moves to the release state (no strobes, tag SUB_A) when quad is low. If quad is high it moves to the first beat (row+secondary column, tag SUB_B).
- R8: After the read beats with tags SUB_B and SUB_D, a high cerr inserts one row-only cycle with the same tag before the next beat. After the last beat (tag SUB_C), a high cerr inserts a no-strobe cycle with tag SUB_B before the release state.
- R9: In the release state, a high cerr leads to the error state (no strobes, tag SUB_D) and a low cerr leads to idle. The error state goes to the row-only state on a request and to idle otherwise.
- R10: Whenever the primary column strobe is active, the secondary column strobe is inactive.
- R11: Idle with no request stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request |
| rd | input | 1 | 1 selects read, 0 selects write |
| stall | input | 1 | Holds column cycles |
| quad | input | 1 | Quad-word burst |
| cerr | input | 1 | Correctable error on the current read beat |
| ras_n | output | 1 | Row strobe, active low |
| casa_n | output | 1 | Primary column strobe, active low |
| casb_n | output | 1 | Secondary column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| tag_n | output | 2 | Inverted sub-state tag |

## Verification
The bench builds the sequencer with the tag permutation SUB_A=2, SUB_B=0, SUB_C=3, SUB_D=1 instead of the identity-like default. With this permutation, a tag mix-up between states that share a strobe pattern becomes visible, and so does the use of a fixed tag value where a parameter belongs. The write-only state's literal zero tag is then also distinct from the idle tag. Directed sequences walk every stall hold and every error insertion. A long run with biased random inputs is then compared with a reference model on every clock.

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter logic [1:0] SUB_A = 2'd0,
  parameter logic [1:0] SUB_B = 2'd1,
  parameter logic [1:0] SUB_C = 2'd2,
  parameter logic [1:0] SUB_D = 2'd3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       rd,
  input  logic       stall,
  input  logic       quad,
  input  logic       cerr,
  output logic       ras_n,
  output logic       casa_n,
  output logic       casb_n,
  output logic       we_n,
  output logic [1:0] tag_n
);
  localparam logic [3:0] P_NONE = 4'b0000, P_ROW = 4'b1000, P_COL = 4'b1100,
                         P_BEAT = 4'b1010, P_WCOL = 4'b1101, P_WBEAT = 4'b1011,
                         P_WE = 4'b0001;
  localparam logic [5:0] IDLE = {P_NONE, SUB_C};
  localparam logic [5:0] ROW  = {P_ROW, SUB_A};
  localparam logic [5:0] RD1  = {P_COL, SUB_B};
  localparam logic [5:0] RD2  = {P_COL, SUB_A};
  localparam logic [5:0] RB1  = {P_BEAT, SUB_B};
  localparam logic [5:0] RE1  = {P_ROW, SUB_B};
  localparam logic [5:0] RB2  = {P_BEAT, SUB_D};
  localparam logic [5:0] RE2  = {P_ROW, SUB_D};
  localparam logic [5:0] RB3  = {P_BEAT, SUB_C};
  localparam logic [5:0] RE3  = {P_NONE, SUB_B};
  localparam logic [5:0] REL  = {P_NONE, SUB_A};
  localparam logic [5:0] ERRX = {P_NONE, SUB_D};
  localparam logic [5:0] WC1  = {P_COL, SUB_D};
  localparam logic [5:0] WC2  = {P_WCOL, SUB_A};
  localparam logic [5:0] WB1  = {P_WBEAT, SUB_B};
  localparam logic [5:0] WC3  = {P_WCOL, SUB_B};
  localparam logic [5:0] WB2  = {P_WBEAT, SUB_D};
  localparam logic [5:0] WC4  = {P_WCOL, SUB_D};
  localparam logic [5:0] WB3  = {P_WBEAT, SUB_C};
  localparam logic [5:0] WEND = {P_WE, 2'b00};

  logic [5:0] st, nx;

  always_comb begin
    case (st)
      IDLE:    nx = req ? ROW : IDLE;
      ROW:     nx = rd ? RD1 : WC1;
      RD1:     nx = stall ? RD1 : RD2;
      RD2:     nx = quad ? RB1 : REL;
      RB1:     nx = cerr ? RE1 : RB2;
      RE1:     nx = RB2;
      RB2:     nx = cerr ? RE2 : RB3;
      RE2:     nx = RB3;
      RB3:     nx = cerr ? RE3 : REL;
      RE3:     nx = REL;
      REL:     nx = cerr ? ERRX : IDLE;
      ERRX:    nx = req ? ROW : IDLE;
      WC1:     nx = stall ? WC1 : WC2;
      WC2:     nx = quad ? (stall ? WC2 : WB1) : WEND;
      WB1:     nx = stall ? WC3 : WB2;
      WC3:     nx = stall ? WC3 : WB2;
      WB2:     nx = stall ? WC4 : WB3;
      WC4:     nx = stall ? WC4 : WB3;
      WB3:     nx = WEND;
      WEND:    nx = IDLE;
      default: nx = IDLE;
    endcase
  end

  always_ff @(posedge clk)
    if (rst) st <= IDLE;
    else     st <= nx;

  assign {ras_n, casa_n, casb_n, we_n, tag_n} = ~st;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter logic [1:0] SUB_A = 2'd0,
  parameter logic [1:0] SUB_B = 2'd1,
  parameter logic [1:0] SUB_C = 2'd2,
  parameter logic [1:0] SUB_D = 2'd3
) (
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic       rd,
  input logic       stall,
  input logic       quad,
  input logic       cerr,
  input logic       ras_n,
  input logic       casa_n,
  input logic       casb_n,
  input logic       we_n,
  input logic [1:0] tag_n
);
  logic [5:0] w;
  assign w = ~{ras_n, casa_n, casb_n, we_n, tag_n};

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (w == {4'b0000, SUB_C}));
  // R3
  start_row_chk: assert property (@(posedge clk) disable iff (rst)
    (w == {4'b0000, SUB_C} && req) |=> (w == {4'b1000, SUB_A}));
  // R11
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (w == {4'b0000, SUB_C} && !req) |=> (w == {4'b0000, SUB_C}));
  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (w == {4'b1100, SUB_B} && stall) |=> $stable(w));
  // R4
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (w == {4'b1100, SUB_D} && stall) |=> $stable(w));
  // R6
  beat_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (w == {4'b1011, SUB_B} && stall) |=> (w == {4'b1101, SUB_B}));
  // R8
  err_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (w == {4'b1010, SUB_B} && cerr) |=> (w == {4'b1000, SUB_B}));
  // R9
  err_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (w == {4'b0000, SUB_D} && req) |=> (w == {4'b1000, SUB_A}));
  // R10
  col_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !casa_n |-> casb_n);
endmodule

bind dram_seq dram_seq_chk #(.SUB_A(SUB_A), .SUB_B(SUB_B), .SUB_C(SUB_C), .SUB_D(SUB_D)) u_chk (
  .clk(clk), .rst(rst), .req(req), .rd(rd), .stall(stall), .quad(quad), .cerr(cerr),
  .ras_n(ras_n), .casa_n(casa_n), .casb_n(casb_n), .we_n(we_n), .tag_n(tag_n));

// File: tb/dram_seq_test.sv
module dram_seq_test;
  localparam logic [1:0] TA = 2'd2, TB = 2'd0, TC = 2'd3, TD = 2'd1;

  logic clk = 0, rst = 1, req = 0, rd = 0, stall = 0, quad = 0, cerr = 0;
  logic ras_n, casa_n, casb_n, we_n;
  logic [1:0] tag_n;
  int checks = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_seq #(.SUB_A(TA), .SUB_B(TB), .SUB_C(TC), .SUB_D(TD)) uut (
    .clk(clk), .rst(rst), .req(req), .rd(rd), .stall(stall), .quad(quad), .cerr(cerr),
    .ras_n(ras_n), .casa_n(casa_n), .casb_n(casb_n), .we_n(we_n), .tag_n(tag_n));

  typedef enum int {IDLE, ROW, RD1, RD2, RB1, RE1, RB2, RE2, RB3, RE3, REL, ERRX,
                    WC1, WC2, WB1, WC3, WB2, WC4, WB3, WEND} mstate_t;
  mstate_t ms = IDLE;

  function automatic logic [5:0] code(mstate_t s);
    case (s)
      IDLE: return {4'b0000, TC};   ROW:  return {4'b1000, TA};
      RD1:  return {4'b1100, TB};   RD2:  return {4'b1100, TA};
      RB1:  return {4'b1010, TB};   RE1:  return {4'b1000, TB};
      RB2:  return {4'b1010, TD};   RE2:  return {4'b1000, TD};
      RB3:  return {4'b1010, TC};   RE3:  return {4'b0000, TB};
      REL:  return {4'b0000, TA};   ERRX: return {4'b0000, TD};
      WC1:  return {4'b1100, TD};   WC2:  return {4'b1101, TA};
      WB1:  return {4'b1011, TB};   WC3:  return {4'b1101, TB};
      WB2:  return {4'b1011, TD};   WC4:  return {4'b1101, TD};
      WB3:  return {4'b1011, TC};   default: return 6'b000100;
    endcase
  endfunction

  function automatic mstate_t advance(mstate_t s);
    mstate_t n = s;
    if (s == IDLE) n = req ? ROW : IDLE;
    else if (s == ROW) n = rd ? RD1 : WC1;
    else if (s == RD1 || s == WC1) n = stall ? s : (s == RD1 ? RD2 : WC2);
    else if (s == RD2) n = quad ? RB1 : REL;
    else if (s == RB1) n = cerr ? RE1 : RB2;
    else if (s == RE1) n = RB2;
    else if (s == RB2) n = cerr ? RE2 : RB3;
    else if (s == RE2) n = RB3;
    else if (s == RB3) n = cerr ? RE3 : REL;
    else if (s == RE3) n = REL;
    else if (s == REL) n = cerr ? ERRX : IDLE;
    else if (s == ERRX) n = req ? ROW : IDLE;
    else if (s == WC2) n = !quad ? WEND : (stall ? WC2 : WB1);
    else if (s == WB1 || s == WC3) n = stall ? WC3 : WB2;
    else if (s == WB2 || s == WC4) n = stall ? WC4 : WB3;
    else if (s == WB3) n = WEND;
    else n = IDLE;
    return n;
  endfunction

  task automatic compare(input string rq);
    logic [5:0] got, exp;
    got = ~{ras_n, casa_n, casb_n, we_n, tag_n};
    exp = code(ms);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: state=%b expected=%b (%s)", rq, got, exp, ms.name());
    end
    if (casa_n === 1'b0) begin
      checks++;
      if (casb_n !== 1'b1) begin
        bad++;
        $display("FAIL R10: casb_n=%b expected=1", casb_n);
      end
    end
  endtask

  task automatic step(input logic r, d, s, q, e, input string rq);
    @(negedge clk);
    req = r; rd = d; stall = s; quad = q; cerr = e;
    @(posedge clk);
    ms = rst ? IDLE : advance(ms);
    #2;
    compare(rq);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    step(0, 0, 0, 0, 0, "R1");
    step(1, 1, 1, 1, 1, "R1");
    rst = 0;
    step(0, 0, 0, 0, 0, "R11");
    step(0, 1, 1, 1, 1, "R11");
    // single write with stall on the first column cycle
    step(1, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");
    // write burst with stalls on the beats
    step(1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, "R6");
    step(0, 0, 1, 1, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    step(0, 0, 1, 1, 0, "R6");
    step(0, 0, 1, 1, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    step(0, 0, 1, 1, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 1, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");
    // read burst with error insertions
    step(1, 1, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 0, "R3");
    step(0, 1, 1, 0, 0, "R4");
    step(0, 1, 0, 0, 0, "R4");
    step(0, 1, 0, 1, 0, "R7");
    step(0, 1, 0, 1, 1, "R8");
    step(0, 1, 0, 1, 0, "R8");
    step(0, 1, 0, 1, 1, "R8");
    step(0, 1, 0, 1, 0, "R8");
    step(0, 1, 0, 1, 1, "R8");
    step(0, 1, 0, 1, 0, "R8");
    step(0, 1, 0, 1, 1, "R9");
    step(1, 1, 0, 0, 0, "R9");
    // single read, release, error state without a request
    step(0, 1, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 1, "R9");
    step(0, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R11");
    // reset in the middle of a burst
    step(1, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 1, 0, "R3");
    rst = 1;
    step(0, 0, 0, 1, 0, "R1");
    rst = 0;
    // long random run against the reference model
    for (int i = 0; i < 4000; i++)
      step(($urandom % 3) == 0, $urandom % 2, ($urandom % 3) == 0,
           $urandom % 2, ($urandom % 3) == 0, "R2");
    finish_run();
  end
endmodule